// File: doc/BRIEF.md
# EDO Output Data Latch

This block sits on the read path of a cached memory, between the source of read data and the data pins. It keeps a byte on the output after the access that produced it has moved on, so a slow reader sees a longer valid window. Whether the stored byte follows new read data or holds its value depends on two inputs taken together: a hold request and the level of the column strobe. The same rule covers both read styles. In static-column reads the strobe stays idle and the hold request alone freezes the data. In page mode the hold request stays high and the strobe pulses select between passing data and holding it.

Read data comes in on a valid/ready stream. `rd_ready` is high only in cycles where a byte can be captured, which means the chip is selected, output enable is active and the latch is transparent. While `rd_ready` is low the source keeps its byte and `rd_valid` high, or drops `rd_valid`. Nothing is captured in a cycle where `rd_valid` is low. The tri-state driver is modelled by `dout_oe`. A byte that was frozen while the chip was selected stays driven after the chip select is released, until the output enable is withdrawn or the latch opens again.

Top module: `edo_out_latch`

## Requirements
- R1: With `hold_en` low, every rising clock edge where `sel_n`=0, `oe_n`=0 and `rd_valid`=1 loads `rd_data`, and `dout` shows that byte from that edge on.
- R2: With `hold_en`=1 and `colstb_n`=1 (static column), `dout` holds its value whatever `rd_data` and `rd_valid` do.
- R3: With `hold_en`=1 (page mode), a cycle with `colstb_n`=0 is transparent and captures as in R1, and a cycle with `colstb_n`=1 holds `dout`.
- R4: `rd_ready` is 1 exactly when `sel_n`=0, `oe_n`=0 and the latch is transparent (`hold_en`=0 or `colstb_n`=0). A cycle with `rd_valid`=0 leaves `dout` unchanged.
- R5: `dout_oe` is 1 in any cycle where `sel_n`=0 and `oe_n`=0.
- R6: `dout_oe` is 0 in the same cycle that `oe_n` is 1, in every mode.
- R7: Suppose data was held (`hold_en`=1, `colstb_n`=1) at a clock edge while `sel_n`=0 and `oe_n`=0. If `sel_n` then rises, `dout_oe` stays 1 for as long as `hold_en`=1, `colstb_n`=1 and `oe_n`=0 remain. Once this is ended by `oe_n`=1, it does not come back while `sel_n` stays 1.
- R8: With `sel_n`=1, `hold_en` going low or `colstb_n` going low ends the drive in that same cycle.
- R9: No capture happens while `sel_n`=1 or `oe_n`=1, even when the latch is transparent and `rd_valid`=1.
- R10: The asynchronous active-low reset clears `dout` to 0 and cancels any drive that was kept past chip-select release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| hold_en | input | 1 | Output hold request, active high |
| colstb_n | input | 1 | Column strobe level, low = strobe asserted |
| rd_valid | input | 1 | Read data valid |
| rd_ready | output | 1 | Latch can accept read data this cycle |
| rd_data | input | 8 | Read data from the cache |
| dout | output | 8 | Latched output byte |
| dout_oe | output | 1 | Output driver enable (high = driven) |

## Verification
The bench steps the latch through transparent reads, a static-column freeze, page-mode strobe pulses, cycles with output enable off, and cycles with valid off. Each of these tells a stored byte apart from a fresh one, because every step puts a different byte on `rd_data`. Chip-select release is tried both after a freeze that was taken while selected and after that freeze has been cancelled by the output enable. This separates the kept drive from a plain selected drive. Ending the kept drive through the hold request, through the strobe and through reset checks that each exit cuts the driver in its own cycle.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic {
    GATE_PASS = 1'b0,
    GATE_HOLD = 1'b1
  } gate_e;

  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_LANE_W = 8;
endpackage

// File: rtl/edo_gate_dec.sv
module edo_gate_dec
  import edo_pkg::*;
(
  input  logic  sel_n,
  input  logic  oe_n,
  input  logic  hold_en,
  input  logic  colstb_n,
  output gate_e gate,
  output logic  access
);
  // The latch holds only when the hold request is high and the strobe is idle.
  // Static column (strobe idle) and page mode (strobe pulsing) share this rule.
  always_comb begin
    gate   = (hold_en && colstb_n) ? GATE_HOLD : GATE_PASS;
    access = !sel_n && !oe_n;
  end
endmodule

// File: rtl/edo_data_hold.sv
module edo_data_hold
  import edo_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gate_e             gate,
  input  logic              access,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic capture;
  assign capture = (gate == GATE_PASS) && access && rd_valid;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (capture) begin
        lane_q <= rd_data[g*LANE_W +: LANE_W];
      end
    end

    assign dout[g*LANE_W +: LANE_W] = lane_q;

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (gate == GATE_HOLD) |=> $stable(lane_q));

    assert_pass_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (gate == GATE_PASS && access && rd_valid) |=>
        (lane_q == $past(rd_data[g*LANE_W +: LANE_W])));

    assert_no_load_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!access) |=> $stable(lane_q));
  end
endmodule

// File: rtl/edo_drive_ctl.sv
module edo_drive_ctl
  import edo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_n,
  input  logic  oe_n,
  input  gate_e gate,
  output logic  dout_oe
);
  logic hold;
  logic keep_q;
  logic keep_d;

  assign hold = (gate == GATE_HOLD);

  // The kept drive starts from a freeze taken while selected. It lasts while
  // the freeze and the output enable last.
  always_comb begin
    keep_d  = hold && !oe_n && (!sel_n || keep_q);
    dout_oe = !oe_n && (!sel_n || (keep_q && hold));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) keep_q <= 1'b0;
    else        keep_q <= keep_d;
  end

  assert_oe_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_oe);

  assert_sel_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !oe_n) |-> dout_oe);

  assert_keep_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !oe_n && hold) ##1 (sel_n && !oe_n && hold) |-> dout_oe);

  assert_open_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !hold) |-> !dout_oe);
endmodule

// File: rtl/edo_out_latch.sv
module edo_out_latch
  import edo_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              hold_en,
  input  logic              colstb_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  gate_e gate;
  logic  access;

  edo_gate_dec u_gate (
    .sel_n    (sel_n),
    .oe_n     (oe_n),
    .hold_en  (hold_en),
    .colstb_n (colstb_n),
    .gate     (gate),
    .access   (access)
  );

  edo_data_hold #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate     (gate),
    .access   (access),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .dout     (dout)
  );

  edo_drive_ctl u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n   (sel_n),
    .oe_n    (oe_n),
    .gate    (gate),
    .dout_oe (dout_oe)
  );

  assign rd_ready = access && (gate == GATE_PASS);

  assert_ready_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en && colstb_n) |-> !rd_ready);

  assert_ready_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || oe_n) |-> !rd_ready);
endmodule

// File: tb/test_edo_out_latch.sv
module test_edo_out_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1;
  logic       oe_n = 1'b1;
  logic       hold_en = 1'b0;
  logic       colstb_n = 1'b1;
  logic       rd_valid = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic       rd_ready;
  logic [7:0] dout;
  logic       dout_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edo_out_latch i_edo_out_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .oe_n     (oe_n),
    .hold_en  (hold_en),
    .colstb_n (colstb_n),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

  // Bit layout: {sel_n, oe_n, hold_en, colstb_n, rd_valid, rd_data[7:0],
  //              exp_oe, exp_ready, exp_dout[7:0]}
  localparam int NV = 19;
  localparam logic [22:0] VEC [NV] = '{
    {5'b00011, 8'hA5, 2'b11, 8'hA5},  // R1 transparent, strobe idle
    {5'b00001, 8'h3C, 2'b11, 8'h3C},  // R1 transparent, strobe low
    {5'b00111, 8'h77, 2'b10, 8'h3C},  // R2 freeze
    {5'b00111, 8'h88, 2'b10, 8'h3C},  // R2 still frozen
    {5'b10111, 8'h99, 2'b10, 8'h3C},  // R7 kept after select release
    {5'b10101, 8'h11, 2'b00, 8'h3C},  // R8 strobe low ends drive, R9 no load
    {5'b00101, 8'h22, 2'b11, 8'h22},  // R3 page pass
    {5'b00111, 8'h33, 2'b10, 8'h22},  // R3 page hold
    {5'b00101, 8'h44, 2'b11, 8'h44},  // R3 page pass again
    {5'b01011, 8'h55, 2'b00, 8'h44},  // R6 oe off, R9 no load
    {5'b11011, 8'h66, 2'b00, 8'h44},  // R9 nothing selected
    {5'b00010, 8'h77, 2'b11, 8'h44},  // R4 valid low, no load
    {5'b00111, 8'h12, 2'b10, 8'h44},  // R2 freeze while selected
    {5'b10110, 8'h00, 2'b10, 8'h44},  // R7 kept
    {5'b11110, 8'h00, 2'b00, 8'h44},  // R6 oe off cuts kept drive
    {5'b10110, 8'h00, 2'b00, 8'h44},  // R7 does not come back
    {5'b00110, 8'h00, 2'b10, 8'h44},  // R5 selected drive
    {5'b10010, 8'h00, 2'b00, 8'h44},  // R8 hold low ends drive
    {5'b00011, 8'hF0, 2'b11, 8'hF0}   // R1 capture resumes
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset dout", dout, 8'h00);
    chk("R10 reset oe", {7'd0, dout_oe}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {sel_n, oe_n, hold_en, colstb_n, rd_valid} = VEC[i][22:18];
      rd_data = VEC[i][17:10];
      #1;
      chk($sformatf("R5/R6/R7/R8 oe step %0d", i), {7'd0, dout_oe}, {7'd0, VEC[i][9]});
      chk($sformatf("R4 ready step %0d", i), {7'd0, rd_ready}, {7'd0, VEC[i][8]});
      @(posedge clk);
      #1;
      chk($sformatf("R1/R2/R3/R9 dout step %0d", i), dout, VEC[i][7:0]);
    end

    // Directed: reset cancels a kept drive (R10)
    @(negedge clk);
    {sel_n, oe_n, hold_en, colstb_n, rd_valid} = 5'b00110;
    @(negedge clk);
    rst_n = 1'b0;
    sel_n = 1'b1;
    #1;
    chk("R10 reset clears dout", dout, 8'h00);
    chk("R10 reset cancels kept drive", {7'd0, dout_oe}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 kept drive stays off", {7'd0, dout_oe}, 8'h00);

    // Directed: static column freeze right after a load (R2)
    @(negedge clk);
    {sel_n, oe_n, hold_en, colstb_n, rd_valid} = 5'b00011;
    rd_data = 8'h5A;
    @(negedge clk);
    hold_en = 1'b1;
    rd_data = 8'hC3;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 freeze over several edges", dout, 8'h5A);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule